// File: doc/BRIEF.md
# DRAM Cycle Decoder Model

This block is a synthesizable device-side stand-in for a small multiplexed-address dynamic RAM with a 4-bit data path. A fast system clock samples the active-low strobes for row, column, write and output enable, together with the address pins. From the order of the strobe edges the block decides what kind of memory cycle the controller has issued. The options are a read, an early write, a delayed (read-modify-write) write, a row-only refresh, a refresh with the column strobe first, and entry into the compressed test mode. It keeps its own refresh row counter and holds the cell contents in a small register file. No analog timing, decay or retention is modelled.

The block is meant to sit on a controller's memory pins in a simulation or emulation build. There it acts as the target the controller must drive correctly. `last_kind` reports the class of each finished RAS cycle. `proto_err` pulses when the strobes break the basic ordering rules. The data bus is split into `dq_in`, `dq_out` and the enable `dq_oe`, so the pad logic outside the block forms the tristate.

Top module: `dram_cycle_model`

## Requirements
- R1: A RAS fall sampled with CAS high latches the row from the address pins. If RAS then rises with no CAS fall, `last_kind` becomes 4 (row-only refresh) and no cell changes.
- R2: A RAS fall sampled with CAS low and WE high is a column-first refresh. `last_kind` becomes 5 and `rfsh_row` advances by one. It reads 0 after reset and wraps from 2047 to 0.
- R3: `test_mode` is 0 after reset. A RAS fall sampled with CAS and WE both low sets it and gives `last_kind` 6. Another such cycle, or a read, leaves it set.
- R4: A row-only refresh or a column-first refresh clears `test_mode`.
- R5: WE low at the sample where CAS falls (with a row latched) is an early write. `dq_in` is stored at the latched row and the column on the address pins, `dq_oe` stays 0 for that access, and `last_kind` becomes 2.
- R6: WE high at the CAS fall is a read. From the next clock, with OE low, `dq_oe` is 1 and `dq_out` carries the addressed cell. `last_kind` becomes 1.
- R7: A WE fall while CAS is low after a read stores `dq_in` into the open cell. `dq_out` then shows the new value, and `last_kind` becomes 3.
- R8: `dq_oe` is 0 whenever CAS or OE is high.
- R9: Several CAS cycles under one RAS low period all use the row latched at the RAS fall.
- R10: In test mode the two lowest column bits are ignored on a write. Each data pin's bit is stored into all four cells of the addressed group of four columns.
- R11: In test mode a read drives each data pin to 1 when that bit agrees over the four cells of the group, and to 0 when it differs.
- R12: A CAS fall while RAS is low and no row is latched gives a one-clock `proto_err` pulse. Legal cycles give none.
- R13: `proto_err` pulses once if RAS is still sampled low `RAS_MAX_CLK` (default 32) clocks after the clock that saw it fall. A shorter low period gives no pulse.
- R14: If CAS is held low after a read while RAS rises and falls again for a refresh, the data stays on the pins throughout that refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address pins |
| dq_in | input | DQ_W | Data from the bus |
| dq_out | output | DQ_W | Data toward the bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| test_mode | output | 1 | Compressed test mode active |
| last_kind | output | 3 | Class of the last completed RAS cycle |
| rfsh_row | output | REF_BITS | Next row of the internal refresh counter |
| proto_err | output | 1 | One-clock protocol violation pulse |

## Verification
Two functions can meet in one stretch of cycles: a read whose data is still on the pins, and a column-first refresh. The bench provokes this by keeping CAS low after a read while it raises and lowers RAS. It then judges that `dq_oe` and `dq_out` keep the read value, that `rfsh_row` steps, and that `last_kind` reports the refresh. A second meeting point is a delayed write inside a read access. There the bench checks the old value before the WE fall and the new value after it, while the CAS access stays open. All other expected data come from a bench-side cell model filled by an exhaustive page-mode sweep of every row and column.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;

   typedef enum logic [2:0] {
      KIND_IDLE = 3'd0,
      KIND_READ = 3'd1,
      KIND_EWR  = 3'd2,
      KIND_DWR  = 3'd3,
      KIND_ROR  = 3'd4,
      KIND_CBR  = 3'd5,
      KIND_WCBR = 3'd6,
      KIND_ROW  = 3'd7
   } cyc_kind_t;

endpackage

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
   parameter int REF_BITS = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   output logic [REF_BITS-1:0] count
);

   if (REF_BITS < 1) begin : g_bad_width
      $error("dram_refresh_ctr: REF_BITS must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (step) count <= count + 1'b1;
   end

   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(count)); // R2

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int DQ_W      = 4,
   parameter int ROW_BITS  = 3,
   parameter int COL_BITS  = 3,
   parameter int FOLD_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                tm,
   input  logic [ROW_BITS-1:0] row,
   input  logic [COL_BITS-1:0] col,
   input  logic [DQ_W-1:0]     din,
   output logic [DQ_W-1:0]     dout
);

   localparam int IDX_W = ROW_BITS + COL_BITS;
   localparam int DEPTH = 1 << IDX_W;
   localparam int FOLD  = 1 << FOLD_BITS;
   localparam int GRP_W = COL_BITS - FOLD_BITS;

   if (FOLD_BITS < 1 || COL_BITS <= FOLD_BITS) begin : g_bad_fold
      $error("dram_cell_array: COL_BITS must exceed FOLD_BITS");
   end

   logic [DQ_W-1:0]  mem [DEPTH];
   logic [IDX_W-1:0] idx;
   logic [GRP_W-1:0] grp_col;

   assign idx     = {row, col};
   assign grp_col = col[COL_BITS-1:FOLD_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         if (tm) begin
            for (int f = 0; f < FOLD; f++)
               mem[{row, grp_col, FOLD_BITS'(f)}] <= din;
         end else begin
            mem[idx] <= din;
         end
      end
   end

   for (genvar b = 0; b < DQ_W; b++) begin : g_pin
      logic [FOLD-1:0] grp;
      always_comb begin
         for (int f = 0; f < FOLD; f++)
            grp[f] = mem[{row, grp_col, FOLD_BITS'(f)}][b];
      end
      assign dout[b] = tm ? ((&grp) | ~(|grp)) : mem[idx][b];
   end

endmodule

// File: rtl/dram_strobe_decode.sv
module dram_strobe_decode
   import dram_model_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int ROW_BITS    = 3,
   parameter int COL_BITS    = 3,
   parameter int RAS_MAX_CLK = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic [ADDR_W-1:0]   addr,
   output logic [ROW_BITS-1:0] row_o,
   output logic [COL_BITS-1:0] col_o,
   output logic                wr_en,
   output logic                rd_act,
   output logic                tm,
   output cyc_kind_t           last_kind,
   output logic                cbr_step,
   output logic                proto_err
);

   localparam int CNT_W = $clog2(RAS_MAX_CLK + 1);

   if (ADDR_W < ROW_BITS || ADDR_W < COL_BITS) begin : g_bad_addr
      $error("dram_strobe_decode: address pins narrower than row or column");
   end
   if (RAS_MAX_CLK < 2) begin : g_bad_ras
      $error("dram_strobe_decode: RAS_MAX_CLK must be at least 2");
   end

   logic                ras_q, cas_q, we_q;
   logic                row_open;
   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_q;
   cyc_kind_t           kind_q;
   logic [CNT_W-1:0]    ras_cnt;

   logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
   logic cas_open, dwr_now, long_now, orphan_cas;

   assign ras_fall   = ras_q & ~ras_n;
   assign ras_rise   = ~ras_q & ras_n;
   assign cas_fall   = cas_q & ~cas_n;
   assign cas_rise   = ~cas_q & cas_n;
   assign we_fall    = we_q & ~we_n;
   assign cas_open   = cas_fall & ~ras_n & row_open;
   assign orphan_cas = cas_fall & ~ras_n & ~row_open;
   assign dwr_now    = we_fall & ~cas_n & ~cas_fall & ~ras_n & row_open & rd_act;
   assign long_now   = ~ras_n & ~ras_fall & (ras_cnt == CNT_W'(RAS_MAX_CLK - 1));
   assign cbr_step   = ras_fall & ~cas_n & we_n;
   assign wr_en      = (cas_open & ~we_n) | dwr_now;
   assign row_o      = row_q;
   assign col_o      = cas_open ? addr[COL_BITS-1:0] : col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q     <= 1'b1;
         cas_q     <= 1'b1;
         we_q      <= 1'b1;
         row_open  <= 1'b0;
         row_q     <= '0;
         col_q     <= '0;
         kind_q    <= KIND_IDLE;
         last_kind <= KIND_IDLE;
         tm        <= 1'b0;
         rd_act    <= 1'b0;
         ras_cnt   <= '0;
         proto_err <= 1'b0;
      end else begin
         ras_q     <= ras_n;
         cas_q     <= cas_n;
         we_q      <= we_n;
         proto_err <= orphan_cas | long_now;

         if (ras_fall) begin
            ras_cnt <= '0;
            if (cas_n) begin
               row_open <= 1'b1;
               row_q    <= addr[ROW_BITS-1:0];
               kind_q   <= KIND_ROW;
            end else if (we_n) begin
               kind_q <= KIND_CBR;
               tm     <= 1'b0;
            end else begin
               kind_q <= KIND_WCBR;
               tm     <= 1'b1;
            end
         end else if (!ras_n && ras_cnt != CNT_W'(RAS_MAX_CLK)) begin
            ras_cnt <= ras_cnt + 1'b1;
         end

         if (cas_open) begin
            col_q <= addr[COL_BITS-1:0];
            if (!we_n) begin
               kind_q <= KIND_EWR;
               rd_act <= 1'b0;
            end else begin
               kind_q <= KIND_READ;
               rd_act <= 1'b1;
            end
         end else if (dwr_now) begin
            kind_q <= KIND_DWR;
         end

         if (cas_rise) rd_act <= 1'b0;

         if (ras_rise) begin
            row_open  <= 1'b0;
            kind_q    <= KIND_IDLE;
            last_kind <= (kind_q == KIND_ROW) ? KIND_ROR : kind_q;
            if (kind_q == KIND_ROW) tm <= 1'b0;
         end
      end
   end

   AST_TM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !cas_n && !we_n) |=> tm); // R3
   AST_TM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fall && !cas_n && we_n) |=> !tm); // R4
   AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && cas_n) |=> !rd_act); // R8
   AST_EWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_act) |=> !rd_act); // R5
   AST_ERR_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> !$past(ras_n)); // R12

endmodule

// File: rtl/dram_cycle_model.sv
module dram_cycle_model #(
   parameter int ADDR_W      = 11,
   parameter int DQ_W        = 4,
   parameter int ROW_BITS    = 3,
   parameter int COL_BITS    = 3,
   parameter int REF_BITS    = 11,
   parameter int RAS_MAX_CLK = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic                oe_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DQ_W-1:0]     dq_in,
   output logic [DQ_W-1:0]     dq_out,
   output logic                dq_oe,
   output logic                test_mode,
   output logic [2:0]          last_kind,
   output logic [REF_BITS-1:0] rfsh_row,
   output logic                proto_err
);

   import dram_model_pkg::*;

   localparam int FOLD_BITS = 2;

   logic [ROW_BITS-1:0] acc_row;
   logic [COL_BITS-1:0] acc_col;
   logic                wr_en, rd_act, cbr_step;
   cyc_kind_t           kind;

   dram_strobe_decode #(
      .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
      .RAS_MAX_CLK(RAS_MAX_CLK)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .addr(addr), .row_o(acc_row), .col_o(acc_col), .wr_en(wr_en),
      .rd_act(rd_act), .tm(test_mode), .last_kind(kind),
      .cbr_step(cbr_step), .proto_err(proto_err)
   );

   dram_refresh_ctr #(.REF_BITS(REF_BITS)) u_refresh (
      .clk(clk), .rst_n(rst_n), .step(cbr_step), .count(rfsh_row)
   );

   dram_cell_array #(
      .DQ_W(DQ_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
      .FOLD_BITS(FOLD_BITS)
   ) u_cells (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tm(test_mode),
      .row(acc_row), .col(acc_col), .din(dq_in), .dout(dq_out)
   );

   assign last_kind = kind;
   assign dq_oe     = rd_act & ~cas_n & ~oe_n;

endmodule

// File: tb/dram_cycle_model_bench.sv
module dram_cycle_model_bench;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [10:0] addr = '0;
   logic [3:0]  dq_in = '0;
   logic [3:0]  dq_out;
   logic        dq_oe, test_mode, proto_err;
   logic [2:0]  last_kind;
   logic [10:0] rfsh_row;

   int n_cmp = 0;
   int n_bad = 0;
   logic [3:0]  em [64];
   logic [10:0] exp_ctr = '0;
   logic        err_seen = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dram_cycle_model u_dram_cycle_model (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .test_mode(test_mode), .last_kind(last_kind), .rfsh_row(rfsh_row),
      .proto_err(proto_err)
   );

   always @(negedge clk) if (proto_err === 1'b1) err_seen = 1'b1;

   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] pat(int r, int c);
      return 4'((r * 5 + c * 3 + 1) & 15);
   endfunction

   function automatic logic [3:0] tm_expect(int r, int c);
      logic [3:0] res;
      int base;
      base = r * 8 + (c & ~3);
      for (int b = 0; b < 4; b++) begin
         logic a0, same;
         a0 = em[base][b];
         same = 1'b1;
         for (int f = 1; f < 4; f++) if (em[base + f][b] != a0) same = 1'b0;
         res[b] = same;
      end
      return res;
   endfunction

   task automatic open_row(int r);
      addr = 11'(r); ras_n = 1'b0; step();
   endtask

   task automatic close_row();
      ras_n = 1'b1; step(); step();
   endtask

   task automatic ewrite(int r, int c, logic [3:0] d, string req);
      addr = 11'(c); dq_in = d; we_n = 1'b0; cas_n = 1'b0; step();
      chk(req, dq_oe, 0);
      cas_n = 1'b1; we_n = 1'b1; step();
      if (test_mode) begin
         for (int f = 0; f < 4; f++) em[r * 8 + (c & ~3) + f] = d;
      end else begin
         em[r * 8 + c] = d;
      end
   endtask

   task automatic cread(logic [3:0] exp, string req);
      oe_n = 1'b0; cas_n = 1'b0; step();
      chk(req, dq_oe, 1);
      chk(req, dq_out, exp);
      cas_n = 1'b1; oe_n = 1'b1; step();
   endtask

   task automatic cbr_cycle();
      cas_n = 1'b0; step(); ras_n = 1'b0; step();
      ras_n = 1'b1; step(); cas_n = 1'b1; step();
      exp_ctr = exp_ctr + 1'b1;
   endtask

   task automatic wcbr_cycle();
      cas_n = 1'b0; we_n = 1'b0; step(); ras_n = 1'b0; step();
      ras_n = 1'b1; step(); cas_n = 1'b1; we_n = 1'b1; step();
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 64; i++) em[i] = '0;
      step(3);
      rst_n = 1'b1;
      step(2);

      // reset state
      chk("R3 reset test_mode", test_mode, 0);
      chk("R2 reset counter", rfsh_row, 0);
      chk("R6 reset kind", last_kind, 0);
      chk("R8 reset dq_oe", dq_oe, 0);
      chk("R12 reset err", proto_err, 0);

      // exhaustive page-mode write then read (R5, R6, R9)
      for (int r = 0; r < 8; r++) begin
         open_row(r);
         for (int c = 0; c < 8; c++) ewrite(r, c, pat(r, c), "R5 early write quiet");
         close_row();
         chk("R5 kind ewrite", last_kind, 2);
      end
      for (int r = 0; r < 8; r++) begin
         open_row(r);
         addr = 11'h7f8;
         for (int c = 0; c < 8; c++) begin
            addr = 11'(c);
            cread(em[r * 8 + c], "R9 page read");
         end
         close_row();
         chk("R6 kind read", last_kind, 1);
      end
      chk("R12 no error on legal cycles", err_seen, 0);

      // delayed write inside a read access (R7, R8)
      begin
         logic [3:0] old_v, new_v;
         old_v = em[2 * 8 + 5];
         new_v = old_v ^ 4'hA;
         open_row(2);
         addr = 11'd5; oe_n = 1'b0; cas_n = 1'b0; step();
         chk("R7 old data before WE", dq_out, old_v);
         we_n = 1'b0; dq_in = new_v; step();
         chk("R7 new data after WE", dq_out, new_v);
         chk("R7 still driving", dq_oe, 1);
         oe_n = 1'b1; #1;
         chk("R8 OE high releases", dq_oe, 0);
         oe_n = 1'b0; #1;
         chk("R8 OE low drives", dq_oe, 1);
         cas_n = 1'b1; #1;
         chk("R8 CAS high releases", dq_oe, 0);
         we_n = 1'b1; oe_n = 1'b1; step();
         close_row();
         chk("R7 kind dwrite", last_kind, 3);
         em[2 * 8 + 5] = new_v;
         open_row(2); addr = 11'd5; cread(new_v, "R7 stored"); close_row();
      end

      // row-only refresh
      open_row(4); close_row();
      chk("R1 kind ror", last_kind, 4);
      open_row(4); addr = 11'd0; cread(em[32], "R1 data kept"); close_row();

      // column-first refresh and counter
      cbr_cycle();
      chk("R2 kind cbr", last_kind, 5);
      chk("R2 counter step", rfsh_row, exp_ctr);

      // hidden refresh with data held on pins (R14)
      open_row(1);
      addr = 11'd3; oe_n = 1'b0; cas_n = 1'b0; step();
      chk("R14 read before", dq_out, em[11]);
      ras_n = 1'b1; step(); step();
      ras_n = 1'b0; step();
      exp_ctr = exp_ctr + 1'b1;
      chk("R14 still driving", dq_oe, 1);
      chk("R14 data held", dq_out, em[11]);
      ras_n = 1'b1; step();
      chk("R14 counter stepped", rfsh_row, exp_ctr);
      cas_n = 1'b1; oe_n = 1'b1; step();
      chk("R14 kind cbr", last_kind, 5);

      // orphan CAS fall (R12)
      cas_n = 1'b0; step(); ras_n = 1'b0; step();
      exp_ctr = exp_ctr + 1'b1;
      cas_n = 1'b1; step();
      err_seen = 1'b0;
      cas_n = 1'b0; step(); step();
      chk("R12 orphan cas", err_seen, 1);
      ras_n = 1'b1; step(); cas_n = 1'b1; step();

      // RAS low window (R13)
      err_seen = 1'b0;
      open_row(0); step(31); close_row();
      chk("R13 within limit", err_seen, 0);
      err_seen = 1'b0;
      open_row(0); step(32); close_row();
      chk("R13 over limit", err_seen, 1);

      // test mode (R3, R4, R10, R11)
      wcbr_cycle();
      chk("R3 enter", test_mode, 1);
      chk("R3 kind wcbr", last_kind, 6);
      open_row(6);
      ewrite(6, 5, 4'b1011, "R10 test write quiet");
      addr = 11'd6; cread(tm_expect(6, 6), "R11 agree");
      close_row();
      chk("R3 read keeps", test_mode, 1);
      open_row(0); close_row();
      chk("R4 ror exits", test_mode, 0);
      open_row(6); ewrite(6, 7, 4'b0011, "R5 early write quiet"); close_row();
      open_row(6); addr = 11'd4; cread(4'b1011, "R10 group filled"); close_row();
      wcbr_cycle(); wcbr_cycle();
      chk("R3 wcbr keeps", test_mode, 1);
      open_row(6); addr = 11'd4; cread(tm_expect(6, 4), "R11 disagree"); close_row();
      chk("R11 expected value", tm_expect(6, 4), 4'b0111);
      cbr_cycle();
      chk("R4 cbr exits", test_mode, 0);
      chk("R2 counter", rfsh_row, exp_ctr);

      // counter wrap
      while (exp_ctr != 11'd2047) cbr_cycle();
      chk("R2 counter top", rfsh_row, 2047);
      cbr_cycle();
      chk("R2 counter wrap", rfsh_row, 0);
      open_row(7); addr = 11'd7; cread(em[63], "R1 data after refresh"); close_row();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule